// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor core whose registers are renamed through a rotating window. Software always sees 32 logical registers: eight globals, eight outs, eight locals and eight ins. A current-window counter picks which physical 16-register set supplies the locals and outs, and the ins come from the shared half of the neighbouring set. A call sequence can therefore pass arguments in its outs and find them as the callee's ins after one window step, without copying any data.

The file has two combinational read ports and one synchronous write port. A dedicated link port stores a return address into out register 7. Save and restore pulses step the window forward or back, and the count wraps around the number of sets. A control bit chooses between the normal and the alternate bank of globals. Register 0 is hard-wired to zero.

Top module: `wrf_top`

## Requirements
- R1: Logical index 0..7 selects a global, 8..15 an out, 16..23 a local and 24..31 an in. Locals and outs hold separate contents in every window.
- R2: In register 24+k of window w+1 is the same storage as out register 8+k of window w, with w+1 taken modulo NSETS.
- R3: Logical register 0 reads as zero on both read ports in both global banks. Writes to it are discarded.
- R4: A pulse on `ag_load` stores `ag_value` in the bank-select bit. When that bit is 1, indices 1..7 use a second bank of globals whose contents are independent of the normal bank.
- R5: `link_en` writes `link_addr` into register 15 of the current window. When `wr_en` is also high in the same cycle, the link write wins and the ordinary write is dropped.
- R6: A `save` pulse adds one to `cur_win` and a `restore` pulse subtracts one, both modulo NSETS. When both are high together, `cur_win` does not change.
- R7: When a read port addresses the register being written in the same cycle, it returns the data being written (write-first).
- R8: A write made in the same cycle as `save`, `restore` or `ag_load` uses the window and bank mapping that was in effect before that change.
- R9: Synchronous active-high `rst` sets `cur_win` to 0 and selects the normal global bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Logical index for read port A |
| rd_a_data | output | DW | Read data from port A (combinational) |
| rd_b_idx | input | 5 | Logical index for read port B |
| rd_b_data | output | DW | Read data from port B (combinational) |
| wr_en | input | 1 | Write enable for the ordinary write |
| wr_idx | input | 5 | Logical index for the write |
| wr_data | input | DW | Write data |
| link_en | input | 1 | Request to write the link address into register 15 |
| link_addr | input | DW | Return address to store |
| save | input | 1 | Step to the next window |
| restore | input | 1 | Step to the previous window |
| ag_load | input | 1 | Load the global-bank select bit |
| ag_value | input | 1 | New bank select value (1 selects the alternate bank) |
| cur_win | output | $clog2(NSETS) | Current window number |

## Verification
Three cases put two functions in the same cycle: a write with a window step, a write with a bank-select change, and a link write with an ordinary write. The bench drives each pair on one clock edge. It then reads back, through the read ports, the old-mapping register and the new-mapping register, and the winner of the link collision. A write can also coincide with a read of the same register. For that case both ports are sampled before the edge, and they must return the incoming data rather than the stored value.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    localparam int LOG_REGS   = 32;
    localparam int GRP_SIZE   = 8;
    localparam int GLB_SLOTS  = 16;   // normal bank + alternate bank
    localparam int SET_SIZE   = 16;   // 8 locals + 8 shared in/out

    typedef enum logic [1:0] {
        GRP_GLB = 2'd0,
        GRP_OUT = 2'd1,
        GRP_LOC = 2'd2,
        GRP_IN  = 2'd3
    } reg_grp_e;

    function automatic reg_grp_e grp_of(input logic [4:0] idx);
        return reg_grp_e'(idx[4:3]);
    endfunction
endpackage

// File: rtl/wrf_map.sv
module wrf_map #(
    parameter int NSETS = 8,
    parameter int CW    = 3,
    parameter int PW    = 8
) (
    input  logic [4:0]    log_idx,
    input  logic [CW-1:0] win,
    input  logic          alt_glb,
    output logic [PW-1:0] phys_idx,
    output logic          is_zero
);
    import wrf_pkg::*;

    logic [CW-1:0] prev_win;
    int            slot;
    int            off;

    always_comb begin
        prev_win = (win == '0) ? CW'(NSETS - 1) : win - CW'(1);
        off      = int'(log_idx[2:0]);
        unique case (grp_of(log_idx))
            GRP_GLB: slot = (alt_glb ? GRP_SIZE : 0) + off;
            GRP_OUT: slot = GLB_SLOTS + int'(win) * SET_SIZE + GRP_SIZE + off;
            GRP_LOC: slot = GLB_SLOTS + int'(win) * SET_SIZE + off;
            default: slot = GLB_SLOTS + int'(prev_win) * SET_SIZE + GRP_SIZE + off;
        endcase
        phys_idx = PW'(slot);
        is_zero  = (log_idx == 5'd0);
    end
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl #(
    parameter int NSETS = 8,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          save,
    input  logic          restore,
    input  logic          ag_load,
    input  logic          ag_value,
    output logic [CW-1:0] win_q,
    output logic          ag_q
);
    typedef struct packed {
        logic [CW-1:0] win;
        logic          ag;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (save && !restore)
            st_d.win = (st_q.win == CW'(NSETS - 1)) ? '0 : st_q.win + CW'(1);
        else if (restore && !save)
            st_d.win = (st_q.win == '0) ? CW'(NSETS - 1) : st_q.win - CW'(1);
        if (ag_load)
            st_d.ag = ag_value;
        if (rst)
            st_d = '0;
    end

    always_ff @(posedge clk) st_q <= st_d;

    assign win_q = st_q.win;
    assign ag_q  = st_q.ag;

    assert_save_step_R6: assert property (@(posedge clk) disable iff (rst)
        (save && !restore) |=> (st_q.win == (($past(st_q.win) == CW'(NSETS - 1)) ? '0 : $past(st_q.win) + CW'(1))));
    assert_restore_step_R6: assert property (@(posedge clk) disable iff (rst)
        (restore && !save) |=> (st_q.win == (($past(st_q.win) == '0) ? CW'(NSETS - 1) : $past(st_q.win) - CW'(1))));
    assert_both_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (save == restore) |=> $stable(st_q.win));
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (st_q.win == '0 && !st_q.ag));
endmodule

// File: rtl/wrf_store.sv
module wrf_store #(
    parameter int DW    = 64,
    parameter int NPHYS = 144,
    parameter int PW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          w_zero,
    input  logic [PW-1:0] w_phys,
    input  logic [DW-1:0] w_data,
    input  logic [PW-1:0] ra_phys,
    input  logic          ra_zero,
    output logic [DW-1:0] ra_data,
    input  logic [PW-1:0] rb_phys,
    input  logic          rb_zero,
    output logic [DW-1:0] rb_data
);
    logic [DW-1:0] regs_d [NPHYS];
    logic [DW-1:0] regs_q [NPHYS];
    logic          w_live;

    assign w_live = we && !w_zero;

    always_comb begin
        regs_d = regs_q;
        if (w_live)
            regs_d[w_phys] = w_data;
    end

    always_ff @(posedge clk) regs_q <= regs_d;

    always_comb begin
        if (ra_zero)                         ra_data = '0;
        else if (w_live && w_phys == ra_phys) ra_data = w_data;
        else                                 ra_data = regs_q[ra_phys];
        if (rb_zero)                         rb_data = '0;
        else if (w_live && w_phys == rb_phys) rb_data = w_data;
        else                                 rb_data = regs_q[rb_phys];
    end
endmodule

// File: rtl/wrf_top.sv
module wrf_top #(
    parameter int DW    = 64,
    parameter int NSETS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [4:0]                 rd_a_idx,
    output logic [DW-1:0]              rd_a_data,
    input  logic [4:0]                 rd_b_idx,
    output logic [DW-1:0]              rd_b_data,
    input  logic                       wr_en,
    input  logic [4:0]                 wr_idx,
    input  logic [DW-1:0]              wr_data,
    input  logic                       link_en,
    input  logic [DW-1:0]              link_addr,
    input  logic                       save,
    input  logic                       restore,
    input  logic                       ag_load,
    input  logic                       ag_value,
    output logic [$clog2(NSETS)-1:0]   cur_win
);
    import wrf_pkg::*;

    localparam int CW    = $clog2(NSETS);
    localparam int NPHYS = GLB_SLOTS + NSETS * SET_SIZE;
    localparam int PW    = $clog2(NPHYS);
    localparam int NPORT = 3;               // 0: write, 1: read A, 2: read B
    localparam logic [4:0] LINK_IDX = 5'd15;

    logic [CW-1:0] win_q;
    logic          ag_q;
    logic          eff_we;
    logic [4:0]    eff_widx;
    logic [DW-1:0] eff_wdata;
    logic [4:0]    port_idx  [NPORT];
    logic [PW-1:0] port_phys [NPORT];
    logic          port_zero [NPORT];

    wrf_ctrl #(.NSETS(NSETS), .CW(CW)) ctrl_i (
        .clk(clk), .rst(rst), .save(save), .restore(restore),
        .ag_load(ag_load), .ag_value(ag_value), .win_q(win_q), .ag_q(ag_q)
    );

    always_comb begin
        eff_we    = link_en || wr_en;
        eff_widx  = link_en ? LINK_IDX : wr_idx;
        eff_wdata = link_en ? link_addr : wr_data;
    end

    assign port_idx[0] = eff_widx;
    assign port_idx[1] = rd_a_idx;
    assign port_idx[2] = rd_b_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_map
        wrf_map #(.NSETS(NSETS), .CW(CW), .PW(PW)) map_i (
            .log_idx(port_idx[p]), .win(win_q), .alt_glb(ag_q),
            .phys_idx(port_phys[p]), .is_zero(port_zero[p])
        );
    end

    wrf_store #(.DW(DW), .NPHYS(NPHYS), .PW(PW)) store_i (
        .clk(clk), .we(eff_we), .w_zero(port_zero[0]), .w_phys(port_phys[0]),
        .w_data(eff_wdata),
        .ra_phys(port_phys[1]), .ra_zero(port_zero[1]), .ra_data(rd_a_data),
        .rb_phys(port_phys[2]), .rb_zero(port_zero[2]), .rb_data(rd_b_data)
    );

    assign cur_win = win_q;

    assert_r0_a_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));
    assert_r0_b_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx == 5'd0) |-> (rd_b_data == '0));
    assert_bypass_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !link_en && wr_idx != 5'd0 && rd_a_idx == wr_idx) |-> (rd_a_data == wr_data));
    assert_link_bypass_R5: assert property (@(posedge clk) disable iff (rst)
        (link_en && rd_b_idx == LINK_IDX) |-> (rd_b_data == link_addr));
endmodule

// File: tb/wrf_top_tb.sv
module wrf_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam int NS = 4;
    localparam int CW = $clog2(NS);

    logic clk = 0, rst = 1;
    logic [4:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = 0, link_addr = 0;
    logic wr_en = 0, link_en = 0, save = 0, restore = 0, ag_load = 0, ag_value = 0;
    logic [CW-1:0] cur_win;
    int checks = 0, errors = 0;
    bit done = 0;
    int ecw = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrf_top #(.DW(DW), .NSETS(NS)) dut_i (
        .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .link_en(link_en), .link_addr(link_addr), .save(save),
        .restore(restore), .ag_load(ag_load), .ag_value(ag_value), .cur_win(cur_win)
    );

    function automatic logic [DW-1:0] wval(int w, int r);
        return 64'hA000_0000_0000_0000 | 64'(w << 8) | 64'(r);
    endfunction

    task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic rd_a(logic [4:0] i, string tag, logic [DW-1:0] exp);
        rd_a_idx = i; #1; chk(tag, rd_a_data, exp);
    endtask

    task automatic wr(logic [4:0] i, logic [DW-1:0] d);
        wr_en = 1; wr_idx = i; wr_data = d; step(); wr_en = 0;
    endtask

    task automatic do_save();
        save = 1; step(); save = 0; ecw = (ecw + 1) % NS;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step(); rst = 0;
        chk("R9 reset window", 64'(cur_win), 0);
        rd_a(0, "R3 r0 after reset", 0);

        // R1/R2: fill every window's outs and locals, then walk and check
        for (int w = 0; w < NS; w++) begin
            for (int r = 8; r < 24; r++) wr(5'(r), wval(w, r));
            do_save();
        end
        chk("R6 save wraps to 0", 64'(cur_win), 0);
        for (int w = 0; w < NS; w++) begin
            for (int r = 8; r < 24; r++) rd_a(5'(r), "R1 outs/locals", wval(w, r));
            for (int k = 0; k < 8; k++) rd_a(5'(24 + k), "R2 ins overlap", wval((w + NS - 1) % NS, 8 + k));
            do_save();
        end

        // R4 globals, R3 r0 writes discarded
        for (int k = 1; k < 8; k++) wr(5'(k), 64'h6000 + 64'(k));
        wr(0, 64'hDEAD);
        rd_a(0, "R3 r0 write ignored", 0);
        ag_load = 1; ag_value = 1; step(); ag_load = 0;
        for (int k = 1; k < 8; k++) wr(5'(k), 64'h7000 + 64'(k));
        wr(0, 64'hBEEF);
        rd_b_idx = 0; #1; chk("R3 r0 alt bank", rd_b_data, 0);
        for (int k = 1; k < 8; k++) rd_a(5'(k), "R4 alt bank", 64'h7000 + 64'(k));
        // R8: write in the cycle that clears the bank bit goes to the alt bank
        ag_load = 1; ag_value = 0; wr_en = 1; wr_idx = 3; wr_data = 64'h7777; step();
        ag_load = 0; wr_en = 0;
        for (int k = 1; k < 8; k++) rd_a(5'(k), "R4 normal bank", 64'h6000 + 64'(k));
        ag_load = 1; ag_value = 1; step(); ag_load = 0;
        rd_a(3, "R8 write used old bank", 64'h7777);
        ag_load = 1; ag_value = 0; step(); ag_load = 0;

        // R5 link write, and link beats ordinary write
        link_en = 1; link_addr = 64'h0000_C0DE_0000_1234;
        wr_en = 1; wr_idx = 15; wr_data = 64'h1111;
        rd_b_idx = 15; #1; chk("R5 link bypass", rd_b_data, 64'h0000_C0DE_0000_1234);
        step(); link_en = 0; wr_en = 0;
        rd_a(15, "R5 link stored", 64'h0000_C0DE_0000_1234);
        link_en = 1; link_addr = 64'h5555; wr_en = 1; wr_idx = 9; wr_data = 64'h9999; step();
        link_en = 0; wr_en = 0;
        rd_a(9, "R5 ordinary write dropped", wval(ecw, 9));
        rd_a(15, "R5 second link", 64'h5555);

        // R7 write-first bypass on both ports
        wr_en = 1; wr_idx = 20; wr_data = 64'hFACE; rd_a_idx = 20; rd_b_idx = 20; #1;
        chk("R7 bypass A", rd_a_data, 64'hFACE);
        chk("R7 bypass B", rd_b_data, 64'hFACE);
        wr_idx = 0; rd_a_idx = 0; #1;
        chk("R3 r0 no bypass", rd_a_data, 0);
        wr_en = 0; step();

        // R8: write with save uses old window
        wr_en = 1; wr_idx = 12; wr_data = 64'h5A5A; save = 1; step();
        wr_en = 0; save = 0; ecw = (ecw + 1) % NS;
        chk("R6 save step", 64'(cur_win), 64'(ecw));
        rd_a(28, "R8 write before save seen as in", 64'h5A5A);
        rd_a(12, "R8 new window out untouched", wval(ecw, 12));

        // R6 restore wrap and save+restore hold
        while (ecw != 0) do_save();
        restore = 1; step(); restore = 0;
        chk("R6 restore wraps", 64'(cur_win), 64'(NS - 1));
        save = 1; restore = 1; step(); save = 0; restore = 0;
        chk("R6 both hold", 64'(cur_win), 64'(NS - 1));

        // R9 reset clears window and bank select
        ag_load = 1; ag_value = 1; step(); ag_load = 0;
        rst = 1; step(); rst = 0;
        chk("R9 window cleared", 64'(cur_win), 0);
        rd_a(5, "R9 normal bank after reset", 64'h6005);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule